// File: doc/BRIEF.md
# Extended Capability Chain Walker

This block walks a chain of extended-capability headers stored in a 4 KB configuration RAM. The chain always starts at byte offset 0x100. Each header is one dword, and its top field points to the next header. A caller supplies a 17-bit target identifier and a start pulse. The engine reads one header per step through a single RAM port. When it stops, it pulses `done` and reports three things: the offset of the matching header (or 0), the offset of the header visited before it, and whether a match was found.

The same engine also extends the chain. For an append request at an offset other than 0x100, it walks with a target that can never match, which leaves it on the tail header. It then rewrites the tail's next-pointer to the new offset and writes the new header. An append at 0x100 starts a fresh chain and needs no walk.

Malformed requests and corrupt chains raise an error flag instead of hanging the engine. This covers misaligned or out-of-window pointers and chains that loop forever.

Top module: `xcap_chain_walker`

## Requirements
- R1: After a synchronous active-low reset, `busy`, `done`, `found` and `err` are low, `res_off` and `res_prev` are 0, and neither `ram_rd` nor `ram_wr` is asserted.
- R2: A search starts at byte offset 0x100. The header layout is ID in bits 15:0, version in bits 19:16, and next byte offset in bits 31:20. On an ID match the engine reports `found`=1, `res_off` = the matching offset, and `res_prev` = the header visited before it (0 for the first).
- R3: If the dword at 0x100 is zero the chain is empty. The result is then `found`=0, `res_off`=0 and `res_prev`=0, even when the target ID is 0.
- R4: A search that reaches a header whose next field is 0 without a match reports `found`=0, `res_off`=0, and `res_prev` = that last header's offset. A target with bit 16 set never matches, so it always ends on the tail.
- R5: Each visited header costs one read cycle plus one decode cycle, because the RAM has one-cycle read latency. `done` is high exactly 2N cycles after the start edge, where N is the number of headers read. `busy` is high in the cycles between start and done and never together with `done`. A read and a write never occur in the same cycle.
- R6: `op_start` is ignored while `busy` is high.
- R7: An append at 0x100 performs no read. It writes {next=0, version, ID} at 0x100, `done` follows one cycle after the start edge, and the result is `res_off`=0x100 and `res_prev`=0.
- R8: An append at another offset walks to the tail and rewrites the tail header's bits 31:20 to the new offset while keeping its bits 19:0. It then writes {next=0, version, ID} at the new offset. `done` comes 2N+2 cycles after start, with `res_off` = the new offset and `res_prev` = the tail offset.
- R9: An append is rejected if its offset is not a multiple of 4, is below 0x100, has a size under 8 bytes, or has offset+size above 4096. A rejected append sets `err` and `done` in the first cycle after the start edge and makes no RAM access.
- R10: An append at an offset other than 0x100 on an empty chain ends with `err`.
- R11: If a next pointer met during a walk is misaligned, below 0x100 or above 0xFF8, the walk ends with `err`.
- R12: A walk reads at most 960 headers. If it still has to follow a link after the 960th read, it ends with `err`.
- R13: Any error result has `found`=0, `res_off`=0, `res_prev`=0 and `err`=1. The next operation that completes without error clears `err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_start | input | 1 | Start pulse, accepted while idle |
| op_append | input | 1 | 1 = append, 0 = search |
| op_id | input | 17 | Search target; bit 16 set never matches. Bits 15:0 are the new ID for an append |
| op_ver | input | 4 | Version for the appended header |
| op_off | input | 12 | Byte offset of the appended header |
| op_size | input | 13 | Byte size of the appended capability |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| found | output | 1 | Search matched |
| err | output | 1 | Operation ended on an error |
| res_off | output | 12 | Matching (or appended) offset, else 0 |
| res_prev | output | 12 | Previous / tail offset |
| ram_rd | output | 1 | RAM read strobe |
| ram_wr | output | 1 | RAM write strobe |
| ram_addr | output | 10 | RAM dword address |
| ram_wdata | output | 32 | RAM write data |
| ram_rdata | input | 32 | RAM read data, valid one cycle after `ram_rd` |

## Verification
The bench targets several corner cases, each paired with the fault it would expose:
- A zero word at 0x100 searched with target 0: a design that tests the ID before the empty check would report a false hit.
- A target whose low 16 bits equal a real ID but with bit 16 set: a design that drops the top bit would stop early instead of on the tail.
- Appends on an empty chain, at the last legal offset, and with each kind of illegal request: a wrong validity check either corrupts RAM or misses the error, and the bench's RAM image comparison shows it.
- A pointer that is misaligned, too low, too high, or points back at its own header: these show whether the step limit stops at exactly 960 reads and whether a wrong link check wanders through RAM.

// File: rtl/xcw_pkg.sv
// Shared constants, header layout and state encoding for the chain walker.
// Assumes a 4 KB byte-addressed space held as 32-bit words.
package xcw_pkg;

    localparam int OFF_W       = 12;
    localparam int WADDR_W     = OFF_W - 2;
    localparam int SZ_W        = OFF_W + 1;
    localparam int SUM_W       = OFF_W + 2;
    localparam int ID_W        = 16;
    localparam int VER_W       = 4;
    localparam int WORD_W      = OFF_W + VER_W + ID_W;
    localparam int KEEP_W      = VER_W + ID_W;
    localparam int SPACE_BYTES = 1 << OFF_W;
    localparam int HDR_BYTES   = 8;

    localparam logic [OFF_W-1:0] LIST_BASE = OFF_W'(256);
    localparam logic [OFF_W-1:0] LAST_HDR  = OFF_W'(SPACE_BYTES - HDR_BYTES);

    // Header word: link in the top field, then version, then identifier.
    typedef struct packed {
        logic [OFF_W-1:0] nxt;
        logic [VER_W-1:0] ver;
        logic [ID_W-1:0]  id;
    } xhdr_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_CHECK,
        ST_PATCH,
        ST_HEAD
    } xstate_t;

    // True when an offset may hold a header: dword aligned and inside the window.
    function automatic logic off_legal(input logic [OFF_W-1:0] o);
        return (o[1:0] == 2'b00) && (o >= LIST_BASE) && (o <= LAST_HDR);
    endfunction

endpackage

// File: rtl/xcw_hdr_decode.sv
// Splits one header word and classifies it against the walk target.
// Pure combinational; assumes the word is the header stored at at_off.
module xcw_hdr_decode
    import xcw_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    input  logic [OFF_W-1:0]  at_off,
    input  logic [ID_W:0]     want,
    output logic              is_empty,
    output logic              is_hit,
    output logic              is_tail,
    output logic              link_bad,
    output logic [OFF_W-1:0]  link,
    output logic [KEEP_W-1:0] keep_lo
);

    xhdr_t hdr;

    // Reinterpret the raw word as header fields.
    always_comb hdr = xhdr_t'(word);

    // Classify the header for the walk controller.
    always_comb begin
        is_empty = (at_off == LIST_BASE) && (word == '0);
        is_hit   = !want[ID_W] && (hdr.id == want[ID_W-1:0]);
        link     = hdr.nxt;
        is_tail  = (hdr.nxt == '0);
        link_bad = !off_legal(hdr.nxt);
        keep_lo  = {hdr.ver, hdr.id};
    end

endmodule

// File: rtl/xcw_step_guard.sv
// Counts headers already followed in the current walk and flags the last
// permitted step. Assumes clr and adv are never asserted together.
module xcw_step_guard #(
    parameter int MAX_STEPS = 960
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic adv,
    output logic at_limit
);

    localparam int CNT_W = $clog2(MAX_STEPS + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MAX_STEPS - 1);

    logic [CNT_W-1:0] cnt_q;

    // Step counter: cleared on a new operation, bumped on each link taken.
    always_ff @(posedge clk) begin
        if (!rst_n)   cnt_q <= '0;
        else if (clr) cnt_q <= '0;
        else if (adv) cnt_q <= cnt_q + 1'b1;
    end

    // The read being decoded is the final one allowed.
    always_comb at_limit = (cnt_q >= LIMIT);

endmodule

// File: rtl/xcw_req_check.sv
// Validates an append request before any RAM access is made.
// Pure combinational; size is in bytes.
module xcw_req_check
    import xcw_pkg::*;
(
    input  logic [OFF_W-1:0] off,
    input  logic [SZ_W-1:0]  size,
    output logic             bad
);

    logic [SUM_W-1:0] end_byte;

    // Range and alignment test on the requested placement.
    always_comb begin
        end_byte = {2'b00, off} + {1'b0, size};
        bad = (off[1:0] != 2'b00)
           || (off < LIST_BASE)
           || (size < SZ_W'(HDR_BYTES))
           || (end_byte > SUM_W'(SPACE_BYTES));
    end

endmodule

// File: rtl/xcap_chain_walker.sv
// Walks the capability header chain in configuration RAM, one dword per
// step, to find an ID or the tail, and can append a new header at the tail.
// Assumes a RAM with one-cycle read latency and write-on-strobe behaviour.
module xcap_chain_walker
    import xcw_pkg::*;
#(
    parameter int MAX_STEPS = 960
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               op_start,
    input  logic               op_append,
    input  logic [ID_W:0]      op_id,
    input  logic [VER_W-1:0]   op_ver,
    input  logic [OFF_W-1:0]   op_off,
    input  logic [SZ_W-1:0]    op_size,
    output logic               busy,
    output logic               done,
    output logic               found,
    output logic               err,
    output logic [OFF_W-1:0]   res_off,
    output logic [OFF_W-1:0]   res_prev,
    output logic               ram_rd,
    output logic               ram_wr,
    output logic [WADDR_W-1:0] ram_addr,
    output logic [WORD_W-1:0]  ram_wdata,
    input  logic [WORD_W-1:0]  ram_rdata
);

    xstate_t            st_q;
    logic               app_q;
    logic [ID_W:0]      tgt_q;
    logic [OFF_W-1:0]   cur_q;
    logic [OFF_W-1:0]   prev_q;
    logic [OFF_W-1:0]   new_off_q;
    xhdr_t              new_hdr_q;
    logic [KEEP_W-1:0]  tail_lo_q;
    logic               done_q;
    logic               found_q;
    logic               err_q;
    logic [OFF_W-1:0]   res_off_q;
    logic [OFF_W-1:0]   res_prev_q;

    logic               is_empty;
    logic               is_hit;
    logic               is_tail;
    logic               link_bad;
    logic [OFF_W-1:0]   link;
    logic [KEEP_W-1:0]  keep_lo;
    logic               at_limit;
    logic               req_bad;
    logic               accept;
    logic               follow;
    xhdr_t              patched;

    xcw_hdr_decode u_dec (
        .word     (ram_rdata),
        .at_off   (cur_q),
        .want     (tgt_q),
        .is_empty (is_empty),
        .is_hit   (is_hit),
        .is_tail  (is_tail),
        .link_bad (link_bad),
        .link     (link),
        .keep_lo  (keep_lo)
    );

    xcw_req_check u_req (
        .off  (op_off),
        .size (op_size),
        .bad  (req_bad)
    );

    xcw_step_guard #(.MAX_STEPS(MAX_STEPS)) u_guard (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (accept),
        .adv      (follow),
        .at_limit (at_limit)
    );

    // Start acceptance and link-follow decisions.
    always_comb begin
        accept = (st_q == ST_IDLE) && op_start;
        follow = (st_q == ST_CHECK) && !is_empty && !is_hit && !is_tail
              && !link_bad && !at_limit;
    end

    // Tail header with only its link field replaced.
    always_comb begin
        patched     = xhdr_t'({OFF_W'(0), tail_lo_q});
        patched.nxt = new_off_q;
    end

    // RAM port drive from the current state.
    always_comb begin
        ram_rd    = (st_q == ST_ISSUE);
        ram_wr    = (st_q == ST_PATCH) || (st_q == ST_HEAD);
        ram_addr  = cur_q[OFF_W-1:2];
        ram_wdata = new_hdr_q;
        if (st_q == ST_PATCH) begin
            ram_addr  = prev_q[OFF_W-1:2];
            ram_wdata = patched;
        end else if (st_q == ST_HEAD) begin
            ram_addr  = new_off_q[OFF_W-1:2];
        end
    end

    // Sequencer: latch request, walk, patch tail, write header, report.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= ST_IDLE;
            app_q      <= 1'b0;
            tgt_q      <= '0;
            cur_q      <= '0;
            prev_q     <= '0;
            new_off_q  <= '0;
            new_hdr_q  <= '0;
            tail_lo_q  <= '0;
            done_q     <= 1'b0;
            found_q    <= 1'b0;
            err_q      <= 1'b0;
            res_off_q  <= '0;
            res_prev_q <= '0;
        end else begin
            done_q <= 1'b0;
            case (st_q)
                ST_IDLE: begin
                    if (op_start) begin
                        app_q         <= op_append;
                        tgt_q         <= op_append ? {1'b1, ID_W'(0)} : op_id;
                        new_off_q     <= op_off;
                        new_hdr_q.nxt <= '0;
                        new_hdr_q.ver <= op_ver;
                        new_hdr_q.id  <= op_id[ID_W-1:0];
                        cur_q         <= LIST_BASE;
                        prev_q        <= '0;
                        if (op_append && req_bad) begin
                            done_q     <= 1'b1;
                            found_q    <= 1'b0;
                            err_q      <= 1'b1;
                            res_off_q  <= '0;
                            res_prev_q <= '0;
                        end else if (op_append && (op_off == LIST_BASE)) begin
                            st_q <= ST_HEAD;
                        end else begin
                            st_q <= ST_ISSUE;
                        end
                    end
                end
                ST_ISSUE: st_q <= ST_CHECK;
                ST_CHECK: begin
                    if (is_empty) begin
                        st_q       <= ST_IDLE;
                        done_q     <= 1'b1;
                        found_q    <= 1'b0;
                        err_q      <= app_q;
                        res_off_q  <= '0;
                        res_prev_q <= '0;
                    end else if (is_hit) begin
                        st_q       <= ST_IDLE;
                        done_q     <= 1'b1;
                        found_q    <= 1'b1;
                        err_q      <= 1'b0;
                        res_off_q  <= cur_q;
                        res_prev_q <= prev_q;
                    end else if (is_tail) begin
                        if (app_q) begin
                            tail_lo_q <= keep_lo;
                            prev_q    <= cur_q;
                            st_q      <= ST_PATCH;
                        end else begin
                            st_q       <= ST_IDLE;
                            done_q     <= 1'b1;
                            found_q    <= 1'b0;
                            err_q      <= 1'b0;
                            res_off_q  <= '0;
                            res_prev_q <= cur_q;
                        end
                    end else if (link_bad || at_limit) begin
                        st_q       <= ST_IDLE;
                        done_q     <= 1'b1;
                        found_q    <= 1'b0;
                        err_q      <= 1'b1;
                        res_off_q  <= '0;
                        res_prev_q <= '0;
                    end else begin
                        prev_q <= cur_q;
                        cur_q  <= link;
                        st_q   <= ST_ISSUE;
                    end
                end
                ST_PATCH: st_q <= ST_HEAD;
                ST_HEAD: begin
                    st_q       <= ST_IDLE;
                    done_q     <= 1'b1;
                    found_q    <= 1'b0;
                    err_q      <= 1'b0;
                    res_off_q  <= new_off_q;
                    res_prev_q <= prev_q;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    // Output mapping.
    always_comb begin
        busy     = (st_q != ST_IDLE);
        done     = done_q;
        found    = found_q;
        err      = err_q;
        res_off  = res_off_q;
        res_prev = res_prev_q;
    end

endmodule

// File: rtl/xcw_walker_chk.sv
// Protocol checks for the chain walker, attached by bind to every instance.
module xcw_walker_chk
    import xcw_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               op_start,
    input logic               busy,
    input logic               done,
    input logic               found,
    input logic               err,
    input logic [OFF_W-1:0]   res_off,
    input logic               ram_rd,
    input logic               ram_wr,
    input logic [WADDR_W-1:0] ram_addr
);

    localparam logic [WADDR_W-1:0] BASE_WORD = LIST_BASE[OFF_W-1:2];

    // R5
    rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ram_rd && ram_wr));

    // R5
    busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    // R5
    rd_then_decode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ram_rd |=> (busy && !ram_rd && !ram_wr));

    // R5
    single_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !op_start) |=> !done);

    // R6
    start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_start && !busy) |=> (busy || done));

    // R2
    hit_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && found) |-> (!err && (res_off >= LIST_BASE) && (res_off[1:0] == 2'b00)));

    // R13
    err_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err) |-> (!found && (res_off == '0)));

    // R8
    wr_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ram_wr |-> (ram_addr >= BASE_WORD));

endmodule

bind xcap_chain_walker xcw_walker_chk u_walker_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_start (op_start),
    .busy     (busy),
    .done     (done),
    .found    (found),
    .err      (err),
    .res_off  (res_off),
    .ram_rd   (ram_rd),
    .ram_wr   (ram_wr),
    .ram_addr (ram_addr)
);

// File: tb/xcap_chain_walker_tb_top.sv
`timescale 1ns/1ps
module xcap_chain_walker_tb_top;

    localparam int MAXS = 960;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        op_start, op_append;
    logic [16:0] op_id;
    logic [3:0]  op_ver;
    logic [11:0] op_off;
    logic [12:0] op_size;
    logic        busy, done, found, err;
    logic [11:0] res_off, res_prev;
    logic        ram_rd, ram_wr;
    logic [9:0]  ram_addr;
    logic [31:0] ram_wdata;
    logic [31:0] ram_rdata = '0;

    logic [31:0] mem  [1024];
    logic [31:0] shad [1024];
    int          acc_cnt = 0;
    int          n_cmp = 0;
    int          n_bad = 0;
    bit          ended = 0;

    always #4 clk = ~clk;

    xcap_chain_walker #(.MAX_STEPS(MAXS)) dut_i (
        .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_append(op_append),
        .op_id(op_id), .op_ver(op_ver), .op_off(op_off), .op_size(op_size),
        .busy(busy), .done(done), .found(found), .err(err),
        .res_off(res_off), .res_prev(res_prev), .ram_rd(ram_rd), .ram_wr(ram_wr),
        .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_rdata(ram_rdata)
    );

    // Behavioural RAM with one-cycle read latency and an access counter.
    always @(posedge clk) begin
        if (ram_wr) mem[ram_addr] <= ram_wdata;
        if (ram_rd) ram_rdata <= mem[ram_addr];
        if (ram_rd || ram_wr) acc_cnt <= acc_cnt + 1;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic report();
        if (!ended) begin
            ended = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // Reference: walks the shadow image and predicts results and timing.
    task automatic model(input bit app, input logic [16:0] id, input logic [11:0] off,
                         input logic [3:0] ver, input logic [12:0] size,
                         output int rd_n, output int wr_n, output bit f, output bit e,
                         output logic [11:0] ro, output logic [11:0] rp);
        logic [11:0] c, p, nx;
        logic [31:0] h;
        bit stop;
        f = 0; e = 0; ro = 0; rp = 0; rd_n = 0; wr_n = 0;
        if (app) begin
            if (off[1:0] != 0 || off < 12'h100 || size < 8 || int'(off) + int'(size) > 4096) begin
                e = 1;
                return;
            end
            if (off == 12'h100) begin
                shad[64] = {12'h000, ver, id[15:0]};
                ro = off; wr_n = 1;
                return;
            end
        end
        c = 12'h100; p = 0; stop = 0;
        while (!stop) begin
            rd_n++;
            h = shad[c >> 2];
            if (c == 12'h100 && h == 0) begin
                stop = 1;
                if (app) e = 1;
            end else if (!app && !id[16] && h[15:0] == id[15:0]) begin
                f = 1; ro = c; rp = p; stop = 1;
            end else if (h[31:20] == 0) begin
                stop = 1;
                rp = c;
                if (app) begin
                    shad[c >> 2]   = {off, h[19:0]};
                    shad[off >> 2] = {12'h000, ver, id[15:0]};
                    ro = off; wr_n = 2;
                end
            end else begin
                nx = h[31:20];
                if (nx[1:0] != 0 || nx < 12'h100 || nx > 12'hFF8 || rd_n >= MAXS) begin
                    e = 1; stop = 1;
                end else begin
                    p = c; c = nx;
                end
            end
        end
        if (e) begin f = 0; ro = 0; rp = 0; end
    endtask

    // Drives one operation and compares busy/done every cycle, then results.
    task automatic run(input bit app, input logic [16:0] id, input logic [11:0] off,
                       input logic [3:0] ver, input logic [12:0] size,
                       input bit poke, input string req);
        int rd_n, wr_n, lat, acc0, diffs;
        bit f, e;
        logic [11:0] ro, rp;
        model(app, id, off, ver, size, rd_n, wr_n, f, e, ro, rp);
        lat = 2 * rd_n + wr_n;
        @(negedge clk);
        acc0 = acc_cnt;
        op_append = app; op_id = id; op_off = off; op_ver = ver; op_size = size;
        op_start = 1;
        @(posedge clk);
        for (int c = 0; c <= lat; c++) begin
            if (c > 0) @(posedge clk);
            @(negedge clk);
            op_start = 0;
            if (poke && c == 0 && lat > 0) begin
                op_start = 1; op_append = 0; op_id = 17'h00001;
            end
            chk(busy == (c < lat), "R5", {req, " busy"}, busy, c < lat);
            chk(done == (c == lat), "R5", {req, " done"}, done, c == lat);
        end
        op_start = 0;
        chk(found == f, req, e ? "found (R13)" : "found", found, f);
        chk(err == e, req, e ? "err (R13)" : "err", err, e);
        chk(res_off == ro, req, e ? "res_off (R13)" : "res_off", res_off, ro);
        chk(res_prev == rp, req, e ? "res_prev (R13)" : "res_prev", res_prev, rp);
        chk(acc_cnt - acc0 == rd_n + wr_n, "R5", {req, " ram accesses"},
            acc_cnt - acc0, rd_n + wr_n);
        diffs = 0;
        for (int i = 0; i < 1024; i++) if (mem[i] !== shad[i]) diffs++;
        chk(diffs == 0, req, "ram image mismatching words", diffs, 0);
    endtask

    task automatic poke_mem(input int idx, input logic [31:0] v);
        @(negedge clk);
        mem[idx] = v;
        shad[idx] = v;
    endtask

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        for (int i = 0; i < 1024; i++) begin mem[i] = '0; shad[i] = '0; end
        rst_n = 0; op_start = 0; op_append = 0; op_id = '0; op_ver = '0;
        op_off = '0; op_size = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(!busy && !done, "R1", "busy/done", {busy, done}, 0);
        chk(!found && !err, "R1", "found/err", {found, err}, 0);
        chk(res_off == 0 && res_prev == 0, "R1", "results", {res_off, res_prev}, 0);
        chk(!ram_rd && !ram_wr, "R1", "ram strobes", {ram_rd, ram_wr}, 0);

        run(0, 17'h00000, 12'h000, 4'h0, 13'd0, 0, "R3");
        run(1, 17'h00022, 12'h140, 4'h1, 13'd16, 0, "R10");
        run(1, 17'h00001, 12'h100, 4'h1, 13'd16, 0, "R7");
        run(1, 17'h0000D, 12'h140, 4'h1, 13'd8, 0, "R8");
        run(1, 17'h00003, 12'h180, 4'h2, 13'd12, 0, "R8");
        run(0, 17'h0000D, 12'h000, 4'h0, 13'd0, 0, "R2");
        run(0, 17'h00003, 12'h000, 4'h0, 13'd0, 1, "R6");
        run(0, 17'h00001, 12'h000, 4'h0, 13'd0, 0, "R2");
        run(0, 17'h00099, 12'h000, 4'h0, 13'd0, 0, "R4");
        run(0, 17'h10000, 12'h000, 4'h0, 13'd0, 0, "R4");
        run(0, 17'h10003, 12'h000, 4'h0, 13'd0, 0, "R4");
        run(1, 17'h00050, 12'h1C2, 4'h1, 13'd16, 0, "R9");
        run(1, 17'h00050, 12'h200, 4'h1, 13'd4, 0, "R9");
        run(1, 17'h00050, 12'hFF8, 4'h1, 13'd16, 0, "R9");
        run(1, 17'h00050, 12'h0C0, 4'h1, 13'd8, 0, "R9");
        run(1, 17'h000AA, 12'hFF8, 4'h1, 13'd8, 0, "R8");

        poke_mem(1022, {12'h1C2, 4'h1, 16'h00AA});
        run(0, 17'h00777, 12'h000, 4'h0, 13'd0, 0, "R11");
        poke_mem(1022, {12'h080, 4'h1, 16'h00AA});
        run(0, 17'h00777, 12'h000, 4'h0, 13'd0, 0, "R11");
        poke_mem(1022, {12'hFFC, 4'h1, 16'h00AA});
        run(0, 17'h00777, 12'h000, 4'h0, 13'd0, 0, "R11");
        poke_mem(1022, {12'hFF8, 4'h1, 16'h00AA});
        run(0, 17'h00777, 12'h000, 4'h0, 13'd0, 0, "R12");
        poke_mem(1022, {12'h000, 4'h1, 16'h00AA});
        run(0, 17'h000AA, 12'h000, 4'h0, 13'd0, 0, "R2");
        chk(err == 0, "R13", "err cleared after good op", err, 0);

        repeat (2) @(negedge clk);
        report();
    end

endmodule